// File: doc/BRIEF.md
# ARINC 429 Queued Word Transmitter

This block takes 32-bit ARINC 429 words from a host as two 16-bit half-word writes, holds up to eight of them in a word queue, and shifts them out serially in bipolar return-to-zero form. The serial data appears on two logic-level outputs. One output pulses for each one bit and the other pulses for each zero bit. An external line driver turns these two outputs into bus levels.

A rate-select input sets the bit period. With the 1 MHz master clock, the period is 10 clocks (fast rate) or 80 clocks (slow rate). Bit 32 of each word can carry the host's own data, or it can be replaced by a generated parity bit whose sense is selectable. The host watches a ready flag that drops once a word is queued. The flag rises again when the queue has drained and the final inter-word gap has elapsed. A transmit-enable input gates the start of each word. A sticky overflow flag records a word that was lost because the queue was full.

Top module: `a429_tx_fifo`

## Requirements
- R1: A pulse on `wr_lo` captures `wr_data` as word bits 1..16 (`wr_data[0]` is bit 1). A later pulse on `wr_hi` supplies bits 17..32 (`wr_data[0]` is bit 17) and queues the word. A `wr_hi` pulse that has no `wr_lo` pulse since the last queued word is ignored.
- R2: The queue holds up to 8 words, and words are sent in the order they were queued.
- R3: The bit period is latched at the first bit of each word. It is 10 clocks when `rate_sel` is 0 and 80 clocks when `rate_sel` is 1.
- R4: When `par_en` is 0 at the `wr_hi` pulse, bit 32 is sent exactly as `wr_data[15]`.
- R5: When `par_en` is 1 at the `wr_hi` pulse, bit 32 is generated from bits 1..31. If `par_even` is 0 the sent word has an odd number of ones; if `par_even` is 1 it has an even number.
- R6: A one bit drives `line_one` high, and a zero bit drives `line_zero` high, for the first half of the bit period. Both outputs are low for the second half, during gaps and while idle, and they are never high together.
- R7: Each word is sent starting with bit 1 and ending with bit 32.
- R8: A word starts only while `tx_en` is 1 and the queue is not empty. Its first bit begins one clock after that condition is sampled.
- R9: When another word is queued and `tx_en` is 1, consecutive words are separated by a null gap of exactly 4 bit periods.
- R10: A `wr_hi` pulse while 8 words are queued is ignored and sets `ovf`. `ovf` is cleared only by reset.
- R11: `ready` is 1 after reset. It is 0 from the clock after a word is queued, and it returns to 1 once the queue is empty and the gap after the last sent word has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (1 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 16 | Half-word from the host |
| wr_lo | input | 1 | Strobe capturing word bits 1..16 |
| wr_hi | input | 1 | Strobe supplying bits 17..32 and queuing the word |
| par_en | input | 1 | 1: generate bit 32; 0: send host bit 32 |
| par_even | input | 1 | Parity sense: 0 odd word, 1 even word |
| rate_sel | input | 1 | 0: period of 10 clocks; 1: period of 80 clocks |
| tx_en | input | 1 | Allows a queued word to start |
| ready | output | 1 | High when queue is empty and the serializer is idle |
| ovf | output | 1 | Sticky flag for a word dropped on a full queue |
| line_one | output | 1 | Return-to-zero pulse for each one bit |
| line_zero | output | 1 | Return-to-zero pulse for each zero bit |

## Verification
On every cycle, the embedded assertions check several invariants. The two line outputs are never high together. `ready` never coincides with an active pulse. The queue is never pushed while full and never popped while empty. The overflow flag never falls. Other behaviour can only be shown by the bench's scenarios, which compare the outputs every clock against a behavioural model and decode the serial stream back into words. These scenarios cover bit order, the latched bit period at both rates, the 4-period gap, both parity senses against host-supplied bit 32, the dropped ninth word, the ignored lone upper strobe, and the timing of `ready`.

// File: rtl/a429_tx_pkg.sv
// Package: shared types and helpers for the queued ARINC 429 transmitter.
// Assumes 32-bit words sent from bit 1 (index 0) to bit 32 (index 31).
package a429_tx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef logic [WORD_W-1:0] a429_word_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_SEND = 2'd1,
        SER_GAP  = 2'd2
    } ser_state_e;

    // Parity bit for position 32: makes the whole word even (even=1) or odd.
    function automatic logic gen_parity(input logic [WORD_W-2:0] low_bits,
                                        input logic even);
        return even ? (^low_bits) : ~(^low_bits);
    endfunction

endpackage

// File: rtl/a429_loader.sv
// Module: two-step half-word loader.
// Captures the lower half on wr_lo. Composes the full word on wr_hi, with
// optional parity in bit 32. Requests a queue push unless the queue is full.
// A full-queue push attempt sets the sticky overflow flag.
// Assumes wr_lo and wr_hi are single-cycle strobes from the host.
module a429_loader
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              q_full,
    output logic              push,
    output a429_word_t        push_word,
    output logic              ovf
);

    logic [HALF_W-1:0] lo_q;
    logic              lo_valid;
    logic              bit32;

    // Select bit 32: host data or generated parity.
    always_comb begin
        bit32 = wr_data[HALF_W-1];
        if (par_en)
            bit32 = gen_parity({wr_data[HALF_W-2:0], lo_q}, par_even);
    end

    assign push_word = {bit32, wr_data[HALF_W-2:0], lo_q};
    assign push      = wr_hi && lo_valid && !q_full;

    // Hold the lower half-word and track whether an upper strobe may follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            lo_valid <= 1'b0;
        end else begin
            if (wr_hi)
                lo_valid <= 1'b0;
            if (wr_lo) begin
                lo_q     <= wr_data;
                lo_valid <= 1'b1;
            end
        end
    end

    // Sticky overflow on an upper strobe that meets a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (wr_hi && q_full)
            ovf <= 1'b1;
    end

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/a429_word_fifo.sv
// Module: word queue with a registered occupancy count.
// The head word is read combinationally and removed by pop.
// Assumes the caller never pushes when full nor pops when empty.
module a429_word_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Write the incoming word into its slot; one enable per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PTR_W'(s)))
                slots[s] <= push_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/a429_serializer.sv
// Module: return-to-zero word serializer.
// Pops a word when enabled and the queue is non-empty. Sends bit 1 first,
// each bit as a half-period pulse on the matching line. Then inserts a
// null gap of GAP_BITS bit periods. The period is latched at word start.
// Assumes word_in is valid whenever q_empty is low.
module a429_serializer
    import a429_tx_pkg::*;
#(
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80,
    parameter int GAP_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       rate_sel,
    input  logic       q_empty,
    input  a429_word_t word_in,
    output logic       pop,
    output logic       busy,
    output logic       line_one,
    output logic       line_zero
);

    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] LAST_GAP = BIT_W'(GAP_BITS - 1);

    ser_state_e       state;
    logic [CNT_W-1:0] cnt, last_cnt, half_cnt;
    logic [BIT_W-1:0] bitn;
    a429_word_t       sh;
    logic             slow;
    logic             bit_end, gap_done, start, pulse;

    assign last_cnt = slow ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
    assign half_cnt = slow ? CNT_W'(SLOW_DIV / 2) : CNT_W'(FAST_DIV / 2);
    assign bit_end  = (cnt == last_cnt);
    assign gap_done = (state == SER_GAP) && bit_end && (bitn == LAST_GAP);
    assign start    = tx_en && !q_empty && ((state == SER_IDLE) || gap_done);
    assign pop      = start;
    assign busy     = (state != SER_IDLE);

    // Active half of a data bit.
    assign pulse     = (state == SER_SEND) && (cnt < half_cnt);
    assign line_one  = pulse && sh[0];
    assign line_zero = pulse && !sh[0];

    // Sequence words, bits and gap periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SER_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            slow  <= 1'b0;
        end else if (start) begin
            state <= SER_SEND;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= word_in;
            slow  <= rate_sel;
        end else begin
            case (state)
                SER_SEND: begin
                    if (bit_end) begin
                        cnt <= '0;
                        sh  <= sh >> 1;
                        if (bitn == LAST_BIT) begin
                            state <= SER_GAP;
                            bitn  <= '0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SER_GAP: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (bitn == LAST_GAP)
                            state <= SER_IDLE;
                        else
                            bitn <= bitn + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    lines_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_one && line_zero));

    // R3
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= last_cnt));

endmodule

// File: rtl/a429_tx_fifo.sv
// Module: top of the queued ARINC 429 transmitter.
// Connects the half-word loader, the word queue and the serializer,
// and derives the ready flag.
// Assumes a single clock domain and host strobes synchronous to clk.
module a429_tx_fifo
    import a429_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              rate_sel,
    input  logic              tx_en,
    output logic              ready,
    output logic              ovf,
    output logic              line_one,
    output logic              line_zero
);

    logic       push, pop, q_empty, q_full, busy;
    a429_word_t push_word, head;

    a429_loader u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data   (wr_data),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .par_en    (par_en),
        .par_even  (par_even),
        .q_full    (q_full),
        .push      (push),
        .push_word (push_word),
        .ovf       (ovf)
    );

    a429_word_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_word),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    a429_serializer #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV),
        .GAP_BITS (GAP_BITS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .rate_sel  (rate_sel),
        .q_empty   (q_empty),
        .word_in   (head),
        .pop       (pop),
        .busy      (busy),
        .line_one  (line_one),
        .line_zero (line_zero)
    );

    // Ready when nothing is queued and the serializer has finished its gap.
    assign ready = q_empty && !busy;

    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!line_one && !line_zero));

endmodule

// File: tb/test_a429_tx_fifo.sv
module test_a429_tx_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic        par_en = 1'b0, par_even = 1'b0, rate_sel = 1'b0, tx_en = 1'b0;
    logic        ready, ovf, line_one, line_zero;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    a429_tx_fifo i_a429_tx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .par_en(par_en), .par_even(par_even), .rate_sel(rate_sel), .tx_en(tx_en),
        .ready(ready), .ovf(ovf), .line_one(line_one), .line_zero(line_zero)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] compose(input bit [15:0] lo, input bit [15:0] hi,
                                          input bit pen, input bit peven);
        bit [31:0] w = {hi, lo};
        if (pen) w[31] = peven ? ($countones(w[30:0]) % 2 == 1)
                               : ($countones(w[30:0]) % 2 == 0);
        return w;
    endfunction

    // ---------------- behavioural reference model ----------------
    int        m_st, m_cnt, m_bit, m_per;
    bit [31:0] m_word;
    bit [31:0] mq[$];
    bit [15:0] m_lo;
    bit        m_lov, m_ovf;
    bit        cmp_on = 0;

    always @(posedge clk) begin
        bit full, start, last;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_bit = 0; m_per = 10; mq.delete();
            m_lov = 0; m_ovf = 0;
        end else begin
            full  = (mq.size() == 8);
            last  = (m_cnt == m_per - 1);
            start = tx_en && (mq.size() > 0) && (m_st == 0 || (m_st == 2 && last && m_bit == 3));
            if (start) begin
                m_word = mq.pop_front(); m_st = 1; m_cnt = 0; m_bit = 0;
                m_per = rate_sel ? 80 : 10;
            end else if (m_st != 0) begin
                if (last) begin
                    m_cnt = 0;
                    if (m_st == 1) begin
                        if (m_bit == 31) begin m_st = 2; m_bit = 0; end else m_bit++;
                    end else begin
                        if (m_bit == 3) m_st = 0; else m_bit++;
                    end
                end else m_cnt++;
            end
            if (wr_hi) begin
                if (full) begin m_ovf = 1; m_lov = 0; end
                else if (m_lov) begin mq.push_back(compose(m_lo, wr_data, par_en, par_even)); m_lov = 0; end
            end
            if (wr_lo) begin m_lo = wr_data; m_lov = 1; end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        bit act, e1, e0, er;
        if (rst_n && cmp_on && !done) begin
            act = (m_st == 1) && (m_cnt < m_per / 2);
            e1  = act && m_word[m_bit];
            e0  = act && !m_word[m_bit];
            er  = (m_st == 0) && (mq.size() == 0);
            chk(line_one == e1, "R6", "line_one", line_one, e1);
            chk(line_zero == e0, "R6", "line_zero", line_zero, e0);
            chk(ready == er, "R11", "ready", ready, er);
            chk(ovf == m_ovf, "R10", "ovf", ovf, m_ovf);
        end
    end

    // ---------------- serial decoder ----------------
    bit [31:0] rx_q[$];
    bit [31:0] rx_w;
    int rx_n = 0, cyc = 0, last_rise = 0, null_run = 0, last_gap = -1, last_per = -1;
    bit p1 = 0, p0 = 0, have_prev = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if ((line_one && !p1) || (line_zero && !p0)) begin
                if (rx_n == 0) begin
                    if (have_prev) last_gap = null_run;
                end else last_per = cyc - last_rise;
                last_rise = cyc;
                rx_w[rx_n] = line_one;
                rx_n++;
                if (rx_n == 32) begin rx_q.push_back(rx_w); rx_n = 0; have_prev = 1; end
            end
            if (!line_one && !line_zero) null_run++; else null_run = 0;
        end
        p1 = line_one; p0 = line_zero;
    end

    // ---------------- stimulus helpers ----------------
    bit [31:0] exp_q[$];
    string     tag_q[$];

    task automatic put_lo(input bit [15:0] d);
        @(negedge clk); wr_data = d; wr_lo = 1;
        @(negedge clk); wr_lo = 0;
    endtask

    task automatic put_hi(input bit [15:0] d);
        @(negedge clk); wr_data = d; wr_hi = 1;
        @(negedge clk); wr_hi = 0;
    endtask

    task automatic load(input bit [15:0] lo, input bit [15:0] hi, input bit keep,
                        input string tag);
        put_lo(lo);
        put_hi(hi);
        if (keep) begin
            exp_q.push_back(compose(lo, hi, par_en, par_even));
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        do @(negedge clk); while (!ready);
    endtask

    task automatic check_rx();
        chk(rx_q.size() == exp_q.size(), "R2", "word count", rx_q.size(), exp_q.size());
        while (rx_q.size() > 0 && exp_q.size() > 0) begin
            bit [31:0] g = rx_q.pop_front();
            bit [31:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            chk(g == e, t, "decoded word", g, e);
        end
        rx_q.delete(); exp_q.delete(); tag_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(ready == 1, "R11", "ready after reset", ready, 1);
        chk(ovf == 0, "R10", "ovf after reset", ovf, 0);
        chk(!line_one && !line_zero, "R6", "lines after reset", {line_one, line_zero}, 0);
        cmp_on = 1;

        // Three words queued while disabled, then sent back to back (R1 R7 R4).
        load(16'h0001, 16'h0000, 1, "R7");
        chk(ready == 0, "R11", "ready after queue", ready, 0);
        load(16'hA5C3, 16'h8F10, 1, "R4");
        load(16'h1234, 16'h0765, 1, "R1");
        repeat (60) @(negedge clk);
        chk(!line_one && !line_zero, "R8", "idle while disabled", {line_one, line_zero}, 0);
        tx_en = 1;
        drain();
        check_rx();
        chk(last_gap == 45, "R9", "null cycles between words", last_gap, 45);
        chk(last_per == 10, "R3", "fast bit period", last_per, 10);

        // Slow rate with even parity, then odd parity at fast rate (R5).
        rate_sel = 1; par_en = 1; par_even = 1;
        load(16'h0F0F, 16'h7001, 1, "R5");
        @(negedge clk); rate_sel = 0;
        drain();
        chk(last_per == 80, "R3", "slow bit period latched", last_per, 80);
        par_even = 0;
        load(16'h0F0F, 16'h7001, 1, "R5");
        load(16'hFFFF, 16'hFFFF, 1, "R5");
        drain();
        check_rx();
        par_en = 0;

        // Lone upper strobe is ignored (R1).
        put_hi(16'hBEEF);
        repeat (3) @(negedge clk);
        chk(ready == 1, "R1", "lone upper strobe queued nothing", ready, 1);
        load(16'h5555, 16'h2AAA, 1, "R1");
        drain();
        check_rx();

        // Overflow: nine words while disabled (R10 R2).
        tx_en = 0;
        for (int k = 0; k < 9; k++)
            load(16'(k * 16'h1111 + 1), 16'(16'h0100 + k), k < 8, "R2");
        @(negedge clk);
        chk(ovf == 1, "R10", "ovf after ninth word", ovf, 1);
        tx_en = 1;
        drain();
        check_rx();
        chk(ovf == 1, "R10", "ovf stays set", ovf, 1);
        chk(ready == 1, "R11", "ready after drain", ready, 1);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule